// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host side of a two-wire serial programming port. A local requester presents a 6-bit command code, an optional 14-bit write word and a one-cycle start strobe. The block then drives the programming clock and data pins, bit by bit and least significant bit first. It holds each half period, the gap between the command and its data phase, and the gap after the data phase, for a set number of system clock cycles. For read commands it releases the data pin and collects the returned word. For programming and erase commands it waits out the target's cycle time. When the command is complete it returns a one-cycle done pulse.

All durations are parameters counted in system clock cycles. The defaults assume a 50 MHz clock. The requester sees a busy level for the whole sequence, including any mandatory wait, and a start raised during that time is ignored. A program-and-verify loop is built above this block as a series of single requests.

Top module: `serprog_host`

## Requirements
- R1: During reset and after it, the clock pin is low, the data pin is low with its output enable high, busy and done are low, and the read word is zero.
- R2: Every command starts with its 6 code bits, least significant first. Each bit keeps the clock high for HALF_CYC cycles and then low for HALF_CYC cycles. The data pin is set up at the rising edge and holds the same value through the falling edge.
- R3: A command that has a data phase leaves exactly HALF_CYC+GAP_CYC cycles between the last falling edge of its code and the first rising edge of its data phase. The data phase is 16 clock periods.
- R4: Codes whose low four bits are 0000 or 0010 send a write frame. The frame is a 0 bit, then the 14-bit word least significant bit first, then a 0 bit. Code 0011 sends the same frame, but only word bits 7..0 are used and frame bits 9..14 are zero.
- R5: For read codes, whose low four bits are 0100 or 0101, the data output enable is low at every clock edge of the data phase. The enable is high at every edge of the code phase, at every edge of all other commands, and at the done pulse.
- R6: A read with low bits 0100 returns frame bits 1..14 as the read word, whatever the start and stop bits carry. The read word keeps its value until the next read completes.
- R7: A read with low bits 0101 returns frame bits 1..8 in read word bits 7..0, with bits 13..8 zero.
- R8: The done pulse arrives between WAIT+GAP_CYC+HALF_CYC-2 and WAIT+GAP_CYC+HALF_CYC cycles after the last falling clock edge of the command. WAIT depends on the low four bits of the code: 1000 selects a programming wait, 1001 and 1011 select ERASE_WAIT_CYC, and every other code selects zero.
- R9: The programming wait is EE_WAIT_CYC when the most recent load command was code 0011. After reset, or when the latest load was 0000 or 0010, it is PGM_WAIT_CYC.
- R10: Busy is high from the cycle after a start is accepted until the done pulse. A start raised while busy is ignored: it produces no clock edges and no done pulse.
- R11: Codes whose low four bits are not listed in R4, R5 or R8 are sent as the 6 code bits only, with no data phase and no wait.
- R12: Each accepted request produces exactly one done pulse, and that pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Request strobe, accepted when not busy |
| cmdIn | input | 6 | Command code, sampled with the accepted strobe |
| wordIn | input | 14 | Write word, sampled with the accepted strobe |
| busyOut | output | 1 | Sequence in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| rdWord | output | 14 | Last word returned by a read command |
| progClk | output | 1 | Programming clock pin |
| progDataOut | output | 1 | Programming data pin, driven value |
| progDataOe | output | 1 | Programming data pin output enable |
| progDataIn | input | 1 | Programming data pin, received value |

## Verification
The hardest behaviour to reach from the ports is the programming wait, because its length depends on which kind of load came earlier. A random mix of codes alone seldom places a begin-programming request directly after each kind of load. Directed sequences therefore cover a begin right after reset, one after a data-memory load and one after a program-memory load, and a random stream of codes then exercises the same history in other orders. A bench-side target model answers reads with start and stop bits forced to 1, so that any leak of the framing bits into the result is visible. Extra starts are pulsed in the middle of a running sequence to check that the block ignores them.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  localparam int CMD_BITS   = 6;
  localparam int FRAME_BITS = 16;
  localparam int WORD_BITS  = 14;
  localparam int EE_BITS    = 8;

  localparam logic [3:0] OP_LOAD_CFG  = 4'h0;
  localparam logic [3:0] OP_LOAD_PGM  = 4'h2;
  localparam logic [3:0] OP_LOAD_EE   = 4'h3;
  localparam logic [3:0] OP_READ_PGM  = 4'h4;
  localparam logic [3:0] OP_READ_EE   = 4'h5;
  localparam logic [3:0] OP_BEGIN     = 4'h8;
  localparam logic [3:0] OP_ERASE_PGM = 4'h9;
  localparam logic [3:0] OP_ERASE_EE  = 4'hB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP,
    ST_DATA,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic clkLevel;
    logic loadCmd;
    logic loadFrame;
    logic shiftBit;
    logic sampleBit;
    logic releaseData;
    logic captureRead;
    logic narrowData;
  } dpCtl_t;

endpackage

// File: rtl/serprog_ctrl.sv
module serprog_ctrl
  import serprog_pkg::*;
#(
  parameter int HALF_CYC       = 6,
  parameter int GAP_CYC        = 50,
  parameter int PGM_WAIT_CYC   = 125000,
  parameter int EE_WAIT_CYC    = 300000,
  parameter int ERASE_WAIT_CYC = 300000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic [3:0] opIn,
  output logic       busyOut,
  output logic       doneOut,
  output dpCtl_t     ctl
);

  localparam int MAX_A   = (PGM_WAIT_CYC > EE_WAIT_CYC) ? PGM_WAIT_CYC : EE_WAIT_CYC;
  localparam int MAX_B   = (ERASE_WAIT_CYC > MAX_A) ? ERASE_WAIT_CYC : MAX_A;
  localparam int MAX_C   = (GAP_CYC > MAX_B) ? GAP_CYC : MAX_B;
  localparam int MAX_ALL = (HALF_CYC > MAX_C) ? HALF_CYC : MAX_C;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);
  localparam int BIT_W   = $clog2(FRAME_BITS + 1);

  localparam logic [CNT_W-1:0] HALF_END  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] CMD_LAST  = BIT_W'(CMD_BITS - 1);
  localparam logic [BIT_W-1:0] FRM_LAST  = BIT_W'(FRAME_BITS - 1);

  seqState_t        state;
  logic [CNT_W-1:0] timer;
  logic [BIT_W-1:0] bitIdx;
  logic             phaseHigh;
  logic             inData;
  logic             eeLoaded;
  logic [3:0]       opReg;

  logic             hasData;
  logic             isRead;
  logic             narrow;
  logic [CNT_W-1:0] waitLen;
  logic             accept;
  logic             shifting;
  logic             halfDone;
  logic             lastBit;
  logic             bitEnd;
  logic             gapEnd;
  logic             waitEnd;
  logic             toData;
  logic             finish;

  // command classification from the latched code
  always_comb begin
    hasData = (opReg == OP_LOAD_CFG) || (opReg == OP_LOAD_PGM) ||
              (opReg == OP_LOAD_EE)  || (opReg == OP_READ_PGM) ||
              (opReg == OP_READ_EE);
    isRead  = (opReg == OP_READ_PGM) || (opReg == OP_READ_EE);
    narrow  = (opReg == OP_LOAD_EE)  || (opReg == OP_READ_EE);
    case (opReg)
      OP_BEGIN:                waitLen = eeLoaded ? CNT_W'(EE_WAIT_CYC) : CNT_W'(PGM_WAIT_CYC);
      OP_ERASE_PGM, OP_ERASE_EE: waitLen = CNT_W'(ERASE_WAIT_CYC);
      default:                 waitLen = '0;
    endcase
  end

  always_comb begin
    accept   = startIn && (state == ST_IDLE);
    shifting = (state == ST_CMD) || (state == ST_DATA);
    halfDone = (timer == HALF_END);
    lastBit  = (state == ST_CMD) ? (bitIdx == CMD_LAST) : (bitIdx == FRM_LAST);
    bitEnd   = shifting && !phaseHigh && halfDone;
    gapEnd   = (state == ST_GAP) && (timer == GAP_END);
    waitEnd  = (state == ST_WAIT) && (timer == waitLen - CNT_W'(1));
    toData   = hasData && !inData;
    finish   = (gapEnd && !toData && (waitLen == '0)) || waitEnd;
  end

  // strobes towards the datapath
  always_comb begin
    ctl.clkLevel    = shifting && phaseHigh;
    ctl.loadCmd     = accept;
    ctl.loadFrame   = (state == ST_CMD) && bitEnd && lastBit && hasData;
    ctl.shiftBit    = bitEnd && !lastBit;
    ctl.sampleBit   = (state == ST_DATA) && isRead && phaseHigh && halfDone &&
                      (bitIdx != '0) && (bitIdx != FRM_LAST);
    ctl.releaseData = (state == ST_DATA) && isRead;
    ctl.captureRead = finish && isRead;
    ctl.narrowData  = narrow;
  end

  assign busyOut = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      bitIdx    <= '0;
      phaseHigh <= 1'b0;
      inData    <= 1'b0;
      eeLoaded  <= 1'b0;
      opReg     <= '0;
      doneOut   <= 1'b0;
    end else begin
      doneOut <= finish;
      case (state)
        ST_IDLE: begin
          if (startIn) begin
            opReg     <= opIn;
            state     <= ST_CMD;
            timer     <= '0;
            bitIdx    <= '0;
            phaseHigh <= 1'b1;
            inData    <= 1'b0;
            if (opIn == OP_LOAD_EE) begin
              eeLoaded <= 1'b1;
            end else if ((opIn == OP_LOAD_PGM) || (opIn == OP_LOAD_CFG)) begin
              eeLoaded <= 1'b0;
            end
          end
        end
        ST_CMD, ST_DATA: begin
          if (halfDone) begin
            timer <= '0;
            if (phaseHigh) begin
              phaseHigh <= 1'b0;
            end else if (lastBit) begin
              state <= ST_GAP;
            end else begin
              bitIdx    <= bitIdx + BIT_W'(1);
              phaseHigh <= 1'b1;
            end
          end else begin
            timer <= timer + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (gapEnd) begin
            timer <= '0;
            if (toData) begin
              state     <= ST_DATA;
              inData    <= 1'b1;
              bitIdx    <= '0;
              phaseHigh <= 1'b1;
            end else if (waitLen == '0) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end else begin
            timer <= timer + CNT_W'(1);
          end
        end
        ST_WAIT: begin
          if (waitEnd) begin
            state <= ST_IDLE;
            timer <= '0;
          end else begin
            timer <= timer + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (!busyOut && $past(busyOut)));

endmodule

// File: rtl/serprog_dp.sv
module serprog_dp
  import serprog_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [CMD_BITS-1:0]  cmdIn,
  input  logic [WORD_BITS-1:0] wordIn,
  input  logic                 progDataIn,
  output logic                 progClk,
  output logic                 progDataOut,
  output logic                 progDataOe,
  output logic [WORD_BITS-1:0] rdWord
);

  localparam int PAD_BITS = FRAME_BITS - CMD_BITS;
  localparam int EE_PAD   = WORD_BITS - EE_BITS;

  logic [FRAME_BITS-1:0] txShift;
  logic [WORD_BITS-1:0]  wordHold;
  logic [WORD_BITS-1:0]  rxShift;
  logic [WORD_BITS-1:0]  framedWord;

  always_comb begin
    framedWord = ctl.narrowData ? {{EE_PAD{1'b0}}, wordHold[EE_BITS-1:0]} : wordHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift     <= '0;
      wordHold    <= '0;
      rxShift     <= '0;
      rdWord      <= '0;
      progClk     <= 1'b0;
      progDataOut <= 1'b0;
      progDataOe  <= 1'b1;
    end else begin
      if (ctl.loadCmd) begin
        txShift  <= {{PAD_BITS{1'b0}}, cmdIn};
        wordHold <= wordIn;
      end else if (ctl.loadFrame) begin
        txShift <= {1'b0, framedWord, 1'b0};
      end else if (ctl.shiftBit) begin
        txShift <= {1'b0, txShift[FRAME_BITS-1:1]};
      end
      if (ctl.sampleBit) begin
        rxShift <= {progDataIn, rxShift[WORD_BITS-1:1]};
      end
      if (ctl.captureRead) begin
        rdWord <= ctl.narrowData ? {{EE_PAD{1'b0}}, rxShift[EE_BITS-1:0]} : rxShift;
      end
      // pins share one register stage so clock, data and enable stay aligned
      progClk     <= ctl.clkLevel;
      progDataOut <= txShift[0];
      progDataOe  <= !ctl.releaseData;
    end
  end

  assert_data_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (progClk && $past(progClk)) |-> $stable(progDataOut));

  assert_release_on_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progDataOe) |-> $rose(progClk));

endmodule

// File: rtl/serprog_host.sv
module serprog_host
  import serprog_pkg::*;
#(
  parameter int HALF_CYC       = 6,
  parameter int GAP_CYC        = 50,
  parameter int PGM_WAIT_CYC   = 125000,
  parameter int EE_WAIT_CYC    = 300000,
  parameter int ERASE_WAIT_CYC = 300000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic [5:0]  cmdIn,
  input  logic [13:0] wordIn,
  output logic        busyOut,
  output logic        doneOut,
  output logic [13:0] rdWord,
  output logic        progClk,
  output logic        progDataOut,
  output logic        progDataOe,
  input  logic        progDataIn
);

  dpCtl_t ctl;

  serprog_ctrl #(
    .HALF_CYC      (HALF_CYC),
    .GAP_CYC       (GAP_CYC),
    .PGM_WAIT_CYC  (PGM_WAIT_CYC),
    .EE_WAIT_CYC   (EE_WAIT_CYC),
    .ERASE_WAIT_CYC(ERASE_WAIT_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .opIn   (cmdIn[3:0]),
    .busyOut(busyOut),
    .doneOut(doneOut),
    .ctl    (ctl)
  );

  serprog_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdIn      (cmdIn),
    .wordIn     (wordIn),
    .progDataIn (progDataIn),
    .progClk    (progClk),
    .progDataOut(progDataOut),
    .progDataOe (progDataOe),
    .rdWord     (rdWord)
  );

  assert_clk_only_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progClk) |-> busyOut);

endmodule

// File: tb/serprog_host_tb.sv
module serprog_host_tb;

  localparam int HALF  = 3;
  localparam int GAP   = 8;
  localparam int PGMW  = 200;
  localparam int EEW   = 350;
  localparam int ERASW = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [5:0]  cmdIn = '0;
  logic [13:0] wordIn = '0;
  logic        busyOut, doneOut, progClk, progDataOut, progDataOe;
  logic [13:0] rdWord;
  logic        progDataIn = 1'b0;

  always #5 clk = ~clk;

  serprog_host #(
    .HALF_CYC(HALF), .GAP_CYC(GAP), .PGM_WAIT_CYC(PGMW),
    .EE_WAIT_CYC(EEW), .ERASE_WAIT_CYC(ERASW)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cmdIn(cmdIn), .wordIn(wordIn),
    .busyOut(busyOut), .doneOut(doneOut), .rdWord(rdWord), .progClk(progClk),
    .progDataOut(progDataOut), .progDataOe(progDataOe), .progDataIn(progDataIn)
  );

  int nChecks = 0;
  int nErr = 0;
  bit eeModel = 0;

  // pin monitor and target model
  int   cyc = 0, nRise = 0, nFall = 0, doneCnt = 0, doneT = 0, reqBase = 0;
  int   riseT [0:4095];
  int   fallT [0:4095];
  logic riseD [0:4095];
  logic fallD [0:4095];
  logic riseOe[0:4095];
  logic fallOe[0:4095];
  logic prevClk = 1'b0;
  logic [15:0] respFrame = '0;
  bit   driveRead = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (progClk && !prevClk && nRise < 4096) begin
        riseT[nRise] = cyc; riseD[nRise] = progDataOut; riseOe[nRise] = progDataOe;
        if (driveRead && (nRise - reqBase) >= 6 && (nRise - reqBase) < 22)
          progDataIn = respFrame[nRise - reqBase - 6];
        nRise++;
      end
      if (!progClk && prevClk && nFall < 4096) begin
        fallT[nFall] = cyc; fallD[nFall] = progDataOut; fallOe[nFall] = progDataOe;
        nFall++;
      end
      if (doneOut) begin doneT = cyc; doneCnt++; end
    end
    prevClk = progClk;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit hasDataF(input logic [3:0] op);
    return op == 4'h0 || op == 4'h2 || op == 4'h3 || op == 4'h4 || op == 4'h5;
  endfunction

  function automatic bit isReadF(input logic [3:0] op);
    return op == 4'h4 || op == 4'h5;
  endfunction

  function automatic int waitF(input logic [3:0] op, input bit ee);
    if (op == 4'h8) return ee ? EEW : PGMW;
    if (op == 4'h9 || op == 4'hB) return ERASW;
    return 0;
  endfunction

  task automatic runReq(input logic [5:0] c, input logic [13:0] w, input bit intrude);
    int r0, f0, d0, nb, wexp, bad, dl, t;
    logic [15:0] resp, expFrame, gotFrame;
    logic [13:0] prevRd, expRd;
    logic [5:0]  gotCmd;
    logic [3:0]  op;
    op = c[3:0];
    resp = 16'($urandom);
    resp[0] = 1'b1; resp[15] = 1'b1;      // framing bits must be stripped
    respFrame = resp;
    driveRead = isReadF(op);
    @(negedge clk);
    while (busyOut) @(negedge clk);
    r0 = nRise; f0 = nFall; d0 = doneCnt; prevRd = rdWord; reqBase = nRise;
    cmdIn = c; wordIn = w; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(busyOut == 1'b1, "R10 busy after accept", busyOut, 1);
    if (intrude) begin
      repeat (4) @(negedge clk);
      cmdIn = 6'h06; wordIn = 14'h1555; startIn = 1'b1;
      @(negedge clk);
      startIn = 1'b0;
    end
    t = 0;
    while (!doneOut && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk);
    check(!doneOut, "R12 done lasts one cycle", doneOut, 0);
    check(doneCnt - d0 == 1, "R12 one done per request", doneCnt - d0, 1);
    nb = hasDataF(op) ? 22 : 6;
    check(nRise - r0 == nb && nFall - f0 == nb, "R11 clock period count", nRise - r0, nb);
    if (nRise - r0 != nb || nFall - f0 != nb) return;
    // code bits LSB first
    for (int k = 0; k < 6; k++) gotCmd[k] = fallD[f0 + k];
    check(gotCmd == c, "R2 code bits", gotCmd, c);
    // stability and half periods
    bad = 0;
    for (int k = 0; k < nb; k++) begin
      if (fallT[f0 + k] - riseT[r0 + k] != HALF) bad++;
      if (!(isReadF(op) && k >= 6) && riseD[r0 + k] != fallD[f0 + k]) bad++;
      if (k != 5 && k + 1 < nb && riseT[r0 + k + 1] - fallT[f0 + k] != HALF) bad++;
    end
    check(bad == 0, "R2 timing or stability errors", bad, 0);
    if (nb == 22) begin
      dl = riseT[r0 + 6] - fallT[f0 + 5];
      check(dl == HALF + GAP, "R3 command to data gap", dl, HALF + GAP);
    end
    if (nb == 22 && !isReadF(op)) begin
      expFrame = (op == 4'h3) ? {1'b0, 6'b0, w[7:0], 1'b0} : {1'b0, w, 1'b0};
      for (int k = 0; k < 16; k++) gotFrame[k] = fallD[f0 + 6 + k];
      check(gotFrame == expFrame, "R4 write frame", gotFrame, expFrame);
    end
    // output enable
    bad = 0;
    for (int k = 0; k < nb; k++) begin
      if (riseOe[r0 + k] != !(isReadF(op) && k >= 6)) bad++;
      if (fallOe[f0 + k] != !(isReadF(op) && k >= 6)) bad++;
    end
    check(bad == 0 && progDataOe, "R5 output enable edges", bad, 0);
    // completion delay
    wexp = waitF(op, eeModel);
    dl = doneT - fallT[f0 + nb - 1];
    check(dl >= wexp + GAP + HALF - 2 && dl <= wexp + GAP + HALF,
          (op == 4'h8) ? "R9 programming wait" : "R8 completion delay", dl, wexp + GAP + HALF - 1);
    if (op == 4'h3) eeModel = 1;
    else if (op == 4'h0 || op == 4'h2) eeModel = 0;
    // read result
    if (op == 4'h4) expRd = resp[14:1];
    else if (op == 4'h5) expRd = {6'b0, resp[8:1]};
    else expRd = prevRd;
    check(rdWord == expRd, (op == 4'h5) ? "R7 data read word" : "R6 read word", rdWord, expRd);
    if (intrude) begin
      repeat (30) @(negedge clk);
      check(nRise - r0 == nb && doneCnt - d0 == 1 && !busyOut,
            "R10 start while busy ignored", nRise - r0, nb);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [5:0] c;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    check(!progClk && !progDataOut && progDataOe && !busyOut && !doneOut && rdWord == 0,
          "R1 state in reset", {progClk, progDataOut, progDataOe, busyOut, doneOut}, 5'b00100);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!progClk && progDataOe && !busyOut && rdWord == 0, "R1 state after reset",
          {progClk, progDataOe, busyOut}, 3'b010);
    // directed corners
    runReq(6'h08, 14'h0000, 0);   // R9 begin right after reset
    runReq(6'h03, 14'h3FA5, 0);   // R4 narrow load with upper bits set
    runReq(6'h08, 14'h0000, 0);   // R9 data-memory wait
    runReq(6'h02, 14'h2AC3, 0);   // R4 full load
    runReq(6'h38, 14'h0000, 0);   // R9 program wait, upper code bits set
    runReq(6'h00, 14'h1FFF, 0);   // R4 configuration load
    runReq(6'h04, 14'h0000, 0);   // R6
    runReq(6'h05, 14'h0000, 0);   // R7
    runReq(6'h06, 14'h0000, 0);   // R6 hold across non-read
    runReq(6'h09, 14'h0000, 0);   // R8 erase
    runReq(6'h0B, 14'h0000, 0);   // R8 erase
    runReq(6'h07, 14'h0000, 0);   // R11 unlisted
    runReq(6'h0F, 14'h0000, 0);   // R11 unlisted
    runReq(6'h06, 14'h0000, 1);   // R10 intrusion
    runReq(6'h04, 14'h0000, 1);   // R10 intrusion during read
    // random stream
    for (int i = 0; i < 40; i++) begin
      c = 6'($urandom);
      runReq(c, 14'($urandom), ($urandom % 8) == 0);
    end
    finishRun();
  end

endmodule